// File: doc/BRIEF.md
# Shared interrupt source router

This block keeps the state of a configurable number of external interrupt sources and routes each one to a single output line. Each output line stands for one pair of a virtual processor (VP) and a CPU interrupt pin. Every source has four pieces of state: a pending bit, an enable bit, a target pin with a map-to-pin flag, and an optional target VP. An output is high when at least one source is pending, enabled and routed to that output's VP and pin. The outputs are registered, so each output follows a change of state one clock later.

Software reaches the block through a simple 32-bit register port. Every access is a full word. Writes take effect on the clock edge that samples them. Read data appears one clock later. The port gives word-wide views of the pending and enable bits. Enables are set and cleared through two separate word registers. A trigger register lets software force a pending bit high or low. There is also one pin-map word and one VP-map word per source. Hardware sources are level-sensitive: the pending bit takes the new input level on every input transition.

The register map uses byte addresses. The pending bitmap words start at 0x0000 and the enable bitmap words at 0x0020. Set-enable words start at 0x0040 and clear-enable words at 0x0060. In all four groups, word k covers sources 32k to 32k+31, with bit b standing for source 32k+b. The trigger register is at 0x0080. Pin-map words are at 0x1000 + 4·s, and VP-map words are at 0x4000 + 32·s. The number of sources must be a nonzero multiple of 8 and at most 256. Output index v·N_PIN + p drives VP v, pin p.

Top module: `irq_router`

## Requirements
- R1: On every transition of a hardware input, the pending bit takes the new level, even while the source is disabled. The pending bitmap then shows the new value on the next read.
- R2: Output v·N_PIN+p is the OR of all sources that are pending, enabled and mapped to VP v and pin p. The output is registered, so it changes exactly one clock after the state that drives it. A disabled or unmapped source never drives an output.
- R3: A write to a set-enable word enables each source whose data bit is 1. Sources whose data bit is 0 keep their enable bit.
- R4: A write to a clear-enable word disables each source whose data bit is 1. The pending bit of a disabled source is kept.
- R5: A bitmap word k is valid only if (k+1)·32 ≤ N_SRC. A write to any other word is ignored, and a read of any other word returns zero.
- R6: In a write to the trigger register, bit 31 is the new pending value and bits 30:0 are the source index. A write whose index is N_SRC or more is ignored.
- R7: If a trigger write and an input transition reach the same source on the same clock edge, the trigger value wins.
- R8: A pin-map word holds the map-to-pin flag in bit 31 and the pin number in the low bits, and it reads back as it was stored. If a write's bits 5:0 exceed N_PIN−1, the whole write is discarded.
- R9: A VP-map write stores the index of the lowest set bit of the data as the target VP. Writing zero makes the source unmapped. A write whose lowest set bit is N_VP or higher is discarded.
- R10: A VP-map read returns 1 shifted left by the target VP, or zero for an unmapped source.
- R11: After reset, every source is disabled, not pending and unmapped, its pin map reads 0x8000_0000, and all outputs are low.
- R12: Read data is registered and appears one clock after the read request. A read of an address that decodes to nothing returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after rd_en |
| irq_in | input | N_SRC | Level-sensitive hardware interrupt sources |
| irq_out | output | N_VP·N_PIN | One interrupt level per VP and pin pair |

## Verification
A hardware input transition and a software trigger write can both update the same pending bit on one clock edge. The bench provokes this by raising a source's input on the same edge that a trigger write clears that source. It then reads the pending bitmap and watches the routed output over the following cycles. The pending bit must read zero and the output must stay low, even though the input stays high. A second case checks that an output stays high when one of two sources routed to it is dropped, and falls only when the second one is dropped too.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int REG_W   = 32;
  localparam int ADDR_W  = 15;
  localparam int BMP_W   = 32;   // sources per bitmap word
  localparam int WORD_IW = 3;    // bitmap word index width (256 / 32)
  localparam int SRC_IW  = 8;    // source index width in map address decode

  // bitmap groups, selected by addr[6:5] in the control region
  localparam logic [1:0] GRP_PEND = 2'd0;
  localparam logic [1:0] GRP_EN   = 2'd1;
  localparam logic [1:0] GRP_SET  = 2'd2;
  localparam logic [1:0] GRP_CLR  = 2'd3;

  localparam logic [ADDR_W-1:0] TRIG_ADDR = 15'h0080;

  // index of the lowest set bit; zero when no bit is set
  function automatic logic [4:0] lowest_one(input logic [REG_W-1:0] v);
    logic [4:0] r;
    r = '0;
    for (int k = REG_W - 1; k >= 0; k--) begin
      if (v[k]) r = 5'(k);
    end
    return r;
  endfunction

endpackage

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_router_pkg::*;
#(
  parameter int N_SRC = 64,
  parameter int N_VP  = 2,
  parameter int N_PIN = 6,
  localparam int PIN_W = (N_PIN > 1) ? $clog2(N_PIN) : 1,
  localparam int VP_W  = (N_VP > 1) ? $clog2(N_VP) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [REG_W-1:0]              wdata,
  output logic [REG_W-1:0]              rdata,
  // state seen for read-back
  input  logic [N_SRC-1:0]              pend_vec,
  input  logic [N_SRC-1:0]              en_vec,
  input  logic [N_SRC-1:0]              flag_vec,
  input  logic [N_SRC-1:0][PIN_W-1:0]   pin_num,
  input  logic [N_SRC-1:0]              vp_ok,
  input  logic [N_SRC-1:0][VP_W-1:0]    vp_idx,
  // decoded write commands
  output logic                          set_we,
  output logic                          clr_we,
  output logic [WORD_IW-1:0]            bmp_word,
  output logic [BMP_W-1:0]              bmp_data,
  output logic                          trig_we,
  output logic [SRC_IW-1:0]             trig_idx,
  output logic                          trig_val,
  output logic                          pin_we,
  output logic [SRC_IW-1:0]             pin_src,
  output logic [PIN_W-1:0]              pin_val,
  output logic                          pin_flag,
  output logic                          vp_we,
  output logic [SRC_IW-1:0]             vp_src,
  output logic                          vp_set,
  output logic [VP_W-1:0]               vp_val
);

  logic              ctl_hit, word_ok, pin_hit, vp_hit, pin_ok, vp_src_ok;
  logic [1:0]        grp;
  logic [4:0]        low;
  logic [REG_W-1:0]  rd_next;

  always_comb begin
    ctl_hit   = (addr[14:7] == '0) && (addr[1:0] == 2'b00);
    grp       = addr[6:5];
    bmp_word  = addr[4:2];
    word_ok   = ((int'(bmp_word) + 1) * BMP_W) <= N_SRC;
    pin_hit   = (addr[14:12] == 3'b001) && (addr[11:10] == 2'b00) && (addr[1:0] == 2'b00);
    pin_src   = addr[9:2];
    pin_ok    = int'(pin_src) < N_SRC;
    vp_hit    = addr[14] && !addr[13] && (addr[4:0] == '0);
    vp_src    = addr[12:5];
    vp_src_ok = int'(vp_src) < N_SRC;
    low       = lowest_one(wdata);
  end

  // write command decode
  always_comb begin
    bmp_data = wdata;
    set_we   = wr_en && ctl_hit && (grp == GRP_SET) && word_ok;
    clr_we   = wr_en && ctl_hit && (grp == GRP_CLR) && word_ok;
    trig_idx = wdata[SRC_IW-1:0];
    trig_val = wdata[31];
    trig_we  = wr_en && (addr == TRIG_ADDR) && (int'(wdata[30:0]) < N_SRC);
    pin_val  = wdata[PIN_W-1:0];
    pin_flag = wdata[31];
    pin_we   = wr_en && pin_hit && pin_ok && (int'(wdata[5:0]) <= N_PIN - 1);
    vp_set   = (wdata != '0);
    vp_val   = low[VP_W-1:0];
    vp_we    = wr_en && vp_hit && vp_src_ok && (!vp_set || (int'(low) < N_VP));
  end

  // read mux
  always_comb begin
    rd_next = '0;
    if (ctl_hit && word_ok && (grp == GRP_PEND || grp == GRP_EN)) begin
      for (int b = 0; b < BMP_W; b++) begin
        if (int'(bmp_word) * BMP_W + b < N_SRC) begin
          rd_next[b] = (grp == GRP_PEND) ? pend_vec[int'(bmp_word) * BMP_W + b]
                                         : en_vec[int'(bmp_word) * BMP_W + b];
        end
      end
    end else if (pin_hit && pin_ok) begin
      rd_next[31]        = flag_vec[pin_src];
      rd_next[PIN_W-1:0] = pin_num[pin_src];
    end else if (vp_hit && vp_src_ok) begin
      if (vp_ok[vp_src]) rd_next = REG_W'(1) << vp_idx[vp_src];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? rd_next : '0;
  end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_router_pkg::*;
#(
  parameter int N_SRC = 64,
  parameter int N_VP  = 2,
  parameter int N_PIN = 6,
  localparam int PIN_W = (N_PIN > 1) ? $clog2(N_PIN) : 1,
  localparam int VP_W  = (N_VP > 1) ? $clog2(N_VP) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_SRC-1:0]              irq_in,
  input  logic                          set_we,
  input  logic                          clr_we,
  input  logic [WORD_IW-1:0]            bmp_word,
  input  logic [BMP_W-1:0]              bmp_data,
  input  logic                          trig_we,
  input  logic [SRC_IW-1:0]             trig_idx,
  input  logic                          trig_val,
  input  logic                          pin_we,
  input  logic [SRC_IW-1:0]             pin_src,
  input  logic [PIN_W-1:0]              pin_val,
  input  logic                          pin_flag,
  input  logic                          vp_we,
  input  logic [SRC_IW-1:0]             vp_src,
  input  logic                          vp_set,
  input  logic [VP_W-1:0]               vp_val,
  output logic [N_SRC-1:0]              irq_q,
  output logic [N_SRC-1:0]              pend_vec,
  output logic [N_SRC-1:0]              en_vec,
  output logic [N_SRC-1:0]              flag_vec,
  output logic [N_SRC-1:0][PIN_W-1:0]   pin_num,
  output logic [N_SRC-1:0]              vp_ok,
  output logic [N_SRC-1:0][VP_W-1:0]    vp_idx
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q    <= '0;
      pend_vec <= '0;
      en_vec   <= '0;
      flag_vec <= '1;
      pin_num  <= '0;
      vp_ok    <= '0;
      vp_idx   <= '0;
    end else begin
      for (int i = 0; i < N_SRC; i++) begin
        irq_q[i] <= irq_in[i];
        // software trigger has priority over an input transition
        if (trig_we && int'(trig_idx) == i)
          pend_vec[i] <= trig_val;
        else if (irq_in[i] != irq_q[i])
          pend_vec[i] <= irq_in[i];

        if (set_we && int'(bmp_word) == i / BMP_W && bmp_data[i % BMP_W])
          en_vec[i] <= 1'b1;
        else if (clr_we && int'(bmp_word) == i / BMP_W && bmp_data[i % BMP_W])
          en_vec[i] <= 1'b0;

        if (pin_we && int'(pin_src) == i) begin
          flag_vec[i] <= pin_flag;
          pin_num[i]  <= pin_val;
        end

        if (vp_we && int'(vp_src) == i) begin
          vp_ok[i]  <= vp_set;
          vp_idx[i] <= vp_set ? vp_val : '0;
        end
      end
    end
  end

endmodule

// File: rtl/irq_out_merge.sv
module irq_out_merge #(
  parameter int N_SRC = 64,
  parameter int N_VP  = 2,
  parameter int N_PIN = 6,
  localparam int PIN_W = (N_PIN > 1) ? $clog2(N_PIN) : 1,
  localparam int VP_W  = (N_VP > 1) ? $clog2(N_VP) : 1,
  localparam int N_OUT = N_VP * N_PIN
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_SRC-1:0]              pend_vec,
  input  logic [N_SRC-1:0]              en_vec,
  input  logic [N_SRC-1:0][PIN_W-1:0]   pin_num,
  input  logic [N_SRC-1:0]              vp_ok,
  input  logic [N_SRC-1:0][VP_W-1:0]    vp_idx,
  output logic [N_OUT-1:0]              irq_out
);

  logic [N_SRC-1:0] live;
  logic [N_OUT-1:0] hit;

  assign live = pend_vec & en_vec & vp_ok;

  for (genvar gv = 0; gv < N_VP; gv++) begin : g_vp
    for (genvar gp = 0; gp < N_PIN; gp++) begin : g_pin
      logic [N_SRC-1:0] match;
      always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
          match[i] = live[i] && (vp_idx[i] == VP_W'(gv)) && (pin_num[i] == PIN_W'(gp));
        end
      end
      assign hit[gv * N_PIN + gp] = |match;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= hit;
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_SRC = 64,
  parameter int N_VP  = 2,
  parameter int N_PIN = 6,
  localparam int PIN_W = (N_PIN > 1) ? $clog2(N_PIN) : 1,
  localparam int VP_W  = (N_VP > 1) ? $clog2(N_VP) : 1,
  localparam int N_OUT = N_VP * N_PIN
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata,
  input  logic [N_SRC-1:0]     irq_in,
  output logic [N_OUT-1:0]     irq_out
);

  if (N_SRC < 8 || N_SRC > 256 || (N_SRC % 8) != 0) begin : g_bad_src
    $error("irq_router: N_SRC must be a nonzero multiple of 8 up to 256");
  end

  logic                         set_we, clr_we, trig_we, trig_val;
  logic                         pin_we, pin_flag, vp_we, vp_set;
  logic [WORD_IW-1:0]           bmp_word;
  logic [BMP_W-1:0]             bmp_data;
  logic [SRC_IW-1:0]            trig_idx, pin_src, vp_src;
  logic [PIN_W-1:0]             pin_val;
  logic [VP_W-1:0]              vp_val;
  logic [N_SRC-1:0]             irq_q, pend_vec, en_vec, flag_vec, vp_ok;
  logic [N_SRC-1:0][PIN_W-1:0]  pin_num;
  logic [N_SRC-1:0][VP_W-1:0]   vp_idx;

  irq_reg_if #(.N_SRC(N_SRC), .N_VP(N_VP), .N_PIN(N_PIN)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .pend_vec(pend_vec), .en_vec(en_vec), .flag_vec(flag_vec),
    .pin_num(pin_num), .vp_ok(vp_ok), .vp_idx(vp_idx),
    .set_we(set_we), .clr_we(clr_we), .bmp_word(bmp_word), .bmp_data(bmp_data),
    .trig_we(trig_we), .trig_idx(trig_idx), .trig_val(trig_val),
    .pin_we(pin_we), .pin_src(pin_src), .pin_val(pin_val), .pin_flag(pin_flag),
    .vp_we(vp_we), .vp_src(vp_src), .vp_set(vp_set), .vp_val(vp_val)
  );

  irq_src_bank #(.N_SRC(N_SRC), .N_VP(N_VP), .N_PIN(N_PIN)) u_bank (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .set_we(set_we), .clr_we(clr_we), .bmp_word(bmp_word), .bmp_data(bmp_data),
    .trig_we(trig_we), .trig_idx(trig_idx), .trig_val(trig_val),
    .pin_we(pin_we), .pin_src(pin_src), .pin_val(pin_val), .pin_flag(pin_flag),
    .vp_we(vp_we), .vp_src(vp_src), .vp_set(vp_set), .vp_val(vp_val),
    .irq_q(irq_q), .pend_vec(pend_vec), .en_vec(en_vec), .flag_vec(flag_vec),
    .pin_num(pin_num), .vp_ok(vp_ok), .vp_idx(vp_idx)
  );

  irq_out_merge #(.N_SRC(N_SRC), .N_VP(N_VP), .N_PIN(N_PIN)) u_merge (
    .clk(clk), .rst(rst), .pend_vec(pend_vec), .en_vec(en_vec),
    .pin_num(pin_num), .vp_ok(vp_ok), .vp_idx(vp_idx), .irq_out(irq_out)
  );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int N_SRC = 64,
  parameter int N_OUT = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wdata,
  input logic [REG_W-1:0]  rdata,
  input logic [N_SRC-1:0]  irq_in,
  input logic [N_SRC-1:0]  irq_q,
  input logic [N_SRC-1:0]  pend_vec,
  input logic [N_SRC-1:0]  en_vec,
  input logic [N_OUT-1:0]  irq_out
);

  logic bad_bmp_rd, vp_rd, bad_trig;

  assign bad_bmp_rd = rd_en && (addr[14:6] == '0) && (addr[1:0] == 2'b00)
                      && ((int'(addr[4:2]) + 1) * BMP_W > N_SRC);
  assign vp_rd      = rd_en && addr[14] && !addr[13] && (addr[4:0] == '0);
  assign bad_trig   = wr_en && (addr == TRIG_ADDR) && (int'(wdata[30:0]) >= N_SRC);

  // R11
  reset_out_clear_chk: assert property (@(posedge clk) rst |=> irq_out == '0);

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (en_vec == '0) |=> (irq_out == '0));

  // R5
  bad_word_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bad_bmp_rd |=> (rdata == '0));

  // R10
  vp_read_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    vp_rd |=> $onehot0(rdata));

  // R6
  bad_trig_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bad_trig && (irq_in == irq_q)) |=> $stable(pend_vec));

endmodule

bind irq_router irq_router_chk #(.N_SRC(N_SRC), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .irq_q(irq_q),
  .pend_vec(pend_vec), .en_vec(en_vec), .irq_out(irq_out)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;

  localparam int N_SRC = 64;
  localparam int N_VP  = 2;
  localparam int N_PIN = 6;
  localparam int N_OUT = N_VP * N_PIN;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [14:0]       addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [N_SRC-1:0]  irq_in = '0;
  logic [N_OUT-1:0]  irq_out;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  irq_router #(.N_SRC(N_SRC), .N_VP(N_VP), .N_PIN(N_PIN)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] a;
    logic [31:0] d;    // write data, or expected read value
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h0000, 32'h0000_0000, "R11"},
    '{1'b0, 16'h0020, 32'h0000_0000, "R11"},
    '{1'b0, 16'h100C, 32'h8000_0000, "R11"},
    '{1'b0, 16'h4060, 32'h0000_0000, "R11"},
    '{1'b1, 16'h0040, 32'h0000_00F0, "R3"},
    '{1'b0, 16'h0020, 32'h0000_00F0, "R3"},
    '{1'b1, 16'h0044, 32'h0000_0001, "R3"},
    '{1'b0, 16'h0024, 32'h0000_0001, "R5"},
    '{1'b1, 16'h0060, 32'h0000_0030, "R4"},
    '{1'b0, 16'h0020, 32'h0000_00C0, "R4"},
    '{1'b1, 16'h0048, 32'hFFFF_FFFF, "R5"},
    '{1'b0, 16'h0020, 32'h0000_00C0, "R5"},
    '{1'b0, 16'h0028, 32'h0000_0000, "R5"},
    '{1'b1, 16'h100C, 32'h8000_0005, "R8"},
    '{1'b0, 16'h100C, 32'h8000_0005, "R8"},
    '{1'b1, 16'h100C, 32'h0000_0006, "R8"},
    '{1'b0, 16'h100C, 32'h8000_0005, "R8"},
    '{1'b1, 16'h100C, 32'h0000_0002, "R8"},
    '{1'b0, 16'h100C, 32'h0000_0002, "R8"},
    '{1'b1, 16'h4060, 32'h0000_000C, "R9"},
    '{1'b0, 16'h4060, 32'h0000_0000, "R9"},
    '{1'b1, 16'h4060, 32'h0000_0006, "R9"},
    '{1'b0, 16'h4060, 32'h0000_0002, "R10"},
    '{1'b1, 16'h4060, 32'h0000_0000, "R9"},
    '{1'b0, 16'h4060, 32'h0000_0000, "R10"},
    '{1'b1, 16'h0080, 32'h8000_0007, "R6"},
    '{1'b0, 16'h0000, 32'h0000_0080, "R6"},
    '{1'b1, 16'h0080, 32'h8000_0040, "R6"},
    '{1'b0, 16'h0000, 32'h0000_0080, "R6"},
    '{1'b0, 16'h0004, 32'h0000_0000, "R6"},
    '{1'b1, 16'h0080, 32'h0000_0007, "R6"},
    '{1'b0, 16'h0000, 32'h0000_0000, "R6"},
    '{1'b0, 16'h0090, 32'h0000_0000, "R12"}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic reg_wr(input logic [14:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [14:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    irq_in = '0;
    step();
    step();
    rst = 1'b0;
  endtask

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    do_reset();

    // register-level vector walk
    for (int n = 0; n < NV; n++) begin
      if (VEC[n].wr) begin
        reg_wr(VEC[n].a[14:0], VEC[n].d);
      end else begin
        reg_rd(VEC[n].a[14:0], r);
        check($sformatf("%s vec%0d", VEC[n].tag, n), r, VEC[n].d);
      end
    end

    do_reset();
    // R11 reset state
    check("R11 outputs", 32'(irq_out), 32'h0);
    reg_rd(15'h0000, r); check("R11 pending", r, 32'h0);
    reg_rd(15'h0020, r); check("R11 enable", r, 32'h0);
    reg_rd(15'h1000, r); check("R11 pin map", r, 32'h8000_0000);
    reg_rd(15'h4000, r); check("R11 vp map", r, 32'h0);

    // R1: pending follows input while disabled; R2: no output when disabled
    irq_in[5] = 1'b1;
    step(); step();
    check("R2 disabled quiet", 32'(irq_out), 32'h0);
    reg_rd(15'h0000, r); check("R1 pend while disabled", r, 32'h20);

    // route source 5 to vp1 pin4 (output 10), then enable
    reg_wr(15'h1014, 32'h8000_0004);
    reg_wr(15'h40A0, 32'h0000_0002);
    reg_wr(15'h0040, 32'h0000_0020);
    check("R2 one cycle latency before", 32'(irq_out), 32'h0);
    step();
    check("R2 routed output", 32'(irq_out), 32'h400);

    // R1: input falls -> pending clears, output follows two edges later
    irq_in[5] = 1'b0;
    step();
    check("R2 output holds one edge", 32'(irq_out), 32'h400);
    step();
    check("R1 input fall clears output", 32'(irq_out), 32'h0);

    // R6: trigger raises pending
    reg_wr(15'h0080, 32'h8000_0005);
    step();
    check("R6 trigger raises output", 32'(irq_out), 32'h400);

    // R7: input rises on the same edge a trigger clears the source
    irq_in[5] = 1'b1;
    reg_wr(15'h0080, 32'h0000_0005);
    reg_rd(15'h0000, r); check("R7 trigger wins", r, 32'h0);
    step();
    check("R7 output stays low", 32'(irq_out), 32'h0);

    // R4: clear enable keeps pending, drops output
    reg_wr(15'h0080, 32'h8000_0005);
    step();
    check("R4 precondition", 32'(irq_out), 32'h400);
    reg_wr(15'h0060, 32'h0000_0020);
    step();
    check("R4 cleared output", 32'(irq_out), 32'h0);
    reg_rd(15'h0000, r); check("R4 pending kept", r, 32'h20);

    // R2: OR of two sources on the same output
    reg_wr(15'h1024, 32'h0000_0004);
    reg_wr(15'h4120, 32'h0000_0002);
    reg_wr(15'h0040, 32'h0000_0220);
    reg_wr(15'h0080, 32'h8000_0009);
    step();
    check("R2 two sources", 32'(irq_out), 32'h400);
    reg_wr(15'h0080, 32'h0000_0005);
    step();
    check("R2 one source left", 32'(irq_out), 32'h400);
    reg_wr(15'h0080, 32'h0000_0009);
    step();
    check("R2 none left", 32'(irq_out), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule